// File: doc/BRIEF.md
# Half-Bridge Deadtime and Shoot-Through Guard

This block conditions the gate commands for one leg of a power bridge. A three-phase inverter places three copies side by side, all built with the same parameters. Each copy takes a pair of active-low switch requests, one for the upper switch and one for the lower switch. It also takes one enable per side from the protection logic. It produces two active-high, registered gate drive signals.

The guard never lets both switches conduct together. When both requests are active at once, both gates are held off. When one gate has turned off and the other is then requested, the second gate waits until the first has been off for a minimum number of clock cycles. If the controller already left a longer gap, the guard adds nothing. The requests pass through a pipeline of the same depth on both sides, so turn-on and turn-off latency match on both sides. A protection enable bypasses that pipeline and drops its gate at the next clock edge. A dropped enable also restarts the off-time count that the opposite side must wait out.

Top module: `hb_deadtime_guard`

## Requirements
- R1: A request input at logic 0 asks for its gate to be on. Input pair (upper=1, lower=1) gives both gates off. Upper=0 with lower=1 gives only the upper gate on. Upper=1 with lower=0 gives only the lower gate on.
- R2: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R3: Input pair (upper=0, lower=0) forces both gates off. This holds whichever gate was on before.
- R4: When no deadtime wait is involved, a change on a request input shows on its gate exactly SYNC_STAGES+1 clock cycles later. The latency is the same for turn-on and turn-off, and the same for both sides.
- R5: A gate never turns on earlier than DT_CYCLES cycles after the opposite gate turned off. A request that arrives sooner is held until exactly DT_CYCLES cycles after that turn-off.
- R6: If the commanded gap between one gate's turn-off and the other gate's turn-on is DT_CYCLES cycles or longer, the output gap equals the commanded gap. No extra delay is added.
- R7: An enable sampled at 0 drives its gate to 0 on that same clock edge, without passing through the request pipeline. When the enable returns to 1, a gate whose request is still held comes back on one cycle later, provided the opposite side's off-time has already elapsed.
- R8: While an enable is 0, the opposite gate cannot turn on. After the enable returns to 1, the opposite gate turns on no earlier than DT_CYCLES cycles after the last edge that sampled that enable at 0.
- R9: While `rst` is 1, both gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi_n | input | 1 | Upper switch request, active low |
| cmd_lo_n | input | 1 | Lower switch request, active low |
| en_hi | input | 1 | Upper side enable from protection, active high |
| en_lo | input | 1 | Lower side enable from protection, active high |
| gate_hi | output | 1 | Upper switch gate drive, active high, registered |
| gate_lo | output | 1 | Lower switch gate drive, active high, registered |

## Verification
Two functions can act in the same cycle. One is the deadtime hold on a newly requested gate. The other is the arrival of that gate's pipelined request, or the release of the opposite side's enable. The bench provokes this overlap in two ways. First, it sweeps the commanded gap from zero to past DT_CYCLES in both directions, so the request either lands inside the hold or after it. Second, it raises a request while the opposite enable is low. In each case it judges the result by the cycle distance between recorded gate edges, compared against the larger of the commanded gap and DT_CYCLES, and against the fixed pipeline latency.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // Bit positions of the two sides inside a side pair
  localparam int SIDE_LO = 0;
  localparam int SIDE_HI = 1;
  localparam int NUM_SIDES = 2;

  typedef logic [NUM_SIDES-1:0] side_vec_t;
endpackage

// File: rtl/hbg_cmd_pipe.sv
// Matched-latency request pipeline and cross-conduction decode.
module hbg_cmd_pipe
  import hbg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_hi_n,
  input  logic      cmd_lo_n,
  output side_vec_t req
);
  localparam int PW = NUM_SIDES * STAGES;

  // Packed shift register; newest pair in the low bits, both sides share depth
  logic [PW-1:0] shift_q;
  side_vec_t     tail;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) shift_q <= '1;
        else     shift_q <= {cmd_hi_n, cmd_lo_n};
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) shift_q <= '1;
        else     shift_q <= {shift_q[PW-NUM_SIDES-1:0], cmd_hi_n, cmd_lo_n};
      end
    end
  endgenerate

  assign tail = shift_q[PW-1 -: NUM_SIDES];

  // Inverting inputs; a request counts only when the other side is idle
  always_comb begin
    req          = '0;
    req[SIDE_HI] = !tail[SIDE_HI] && tail[SIDE_LO];
    req[SIDE_LO] = !tail[SIDE_LO] && tail[SIDE_HI];
  end
endmodule

// File: rtl/hbg_off_timer.sv
// Counts how long one gate has been off while its side is enabled.
module hbg_off_timer #(
  parameter int DT_CYCLES = 106
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_q,
  input  logic en,
  output logic ready
);
  localparam int CW = (DT_CYCLES > 1) ? $clog2(DT_CYCLES) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(DT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (gate_q || !en) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  // Opposite side may switch on in the next edge once this holds
  assign ready = !gate_q && en && (cnt_q == LIMIT);
endmodule

// File: rtl/hb_deadtime_guard.sv
module hb_deadtime_guard
  import hbg_pkg::*;
#(
  parameter int DT_CYCLES   = 106,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_hi_n,
  input  logic cmd_lo_n,
  input  logic en_hi,
  input  logic en_lo,
  output logic gate_hi,
  output logic gate_lo
);
  side_vec_t req;
  side_vec_t en_v;
  side_vec_t gate_q;
  side_vec_t gate_d;
  side_vec_t ready;

  assign en_v[SIDE_HI] = en_hi;
  assign en_v[SIDE_LO] = en_lo;

  hbg_cmd_pipe #(.STAGES(SYNC_STAGES)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .cmd_hi_n (cmd_hi_n),
    .cmd_lo_n (cmd_lo_n),
    .req      (req)
  );

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      hbg_off_timer #(.DT_CYCLES(DT_CYCLES)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .gate_q (gate_q[s]),
        .en     (en_v[s]),
        .ready  (ready[s])
      );
      // A gate may rise only once the opposite side reports its off-time done
      assign gate_d[s] = en_v[s] && req[s] && ready[NUM_SIDES-1-s];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) gate_q <= '0;
    else     gate_q <= gate_d;
  end

  assign gate_hi = gate_q[SIDE_HI];
  assign gate_lo = gate_q[SIDE_LO];
endmodule

// File: rtl/hbg_guard_chk.sv
module hbg_guard_chk #(
  parameter int DT_CYCLES = 106
) (
  input logic clk,
  input logic rst,
  input logic en_hi,
  input logic en_lo,
  input logic gate_hi,
  input logic gate_lo
);
  localparam int CW = $clog2(DT_CYCLES + 1);
  localparam logic [CW-1:0] SAT = CW'(DT_CYCLES);

  // Independent off-time counters, saturating at DT_CYCLES
  logic [CW-1:0] hi_off_q;
  logic [CW-1:0] lo_off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_off_q <= '0;
      lo_off_q <= '0;
    end else begin
      if (gate_hi || !en_hi)  hi_off_q <= '0;
      else if (hi_off_q != SAT) hi_off_q <= hi_off_q + 1'b1;
      if (gate_lo || !en_lo)  lo_off_q <= '0;
      else if (lo_off_q != SAT) lo_off_q <= lo_off_q + 1'b1;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(gate_hi && gate_lo)); // R2
  AST_HI_WAITS_GAP: assert property (@(posedge clk) disable iff (rst) $rose(gate_hi) |-> (lo_off_q == SAT)); // R5
  AST_LO_WAITS_GAP: assert property (@(posedge clk) disable iff (rst) $rose(gate_lo) |-> (hi_off_q == SAT)); // R5
  AST_EN_HI_CUTS: assert property (@(posedge clk) disable iff (rst) !en_hi |=> !gate_hi); // R7
  AST_EN_LO_CUTS: assert property (@(posedge clk) disable iff (rst) !en_lo |=> !gate_lo); // R7
  AST_EN_LO_BLOCKS_HI: assert property (@(posedge clk) disable iff (rst) !en_lo |=> !$rose(gate_hi)); // R8
endmodule

bind hb_deadtime_guard hbg_guard_chk #(.DT_CYCLES(DT_CYCLES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_hi   (en_hi),
  .en_lo   (en_lo),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo)
);

// File: tb/sim_hb_deadtime_guard.sv
module sim_hb_deadtime_guard;
  localparam int DT  = 3;
  localparam int STG = 2;
  localparam int LAT = STG + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_hi_n = 1'b1;
  logic cmd_lo_n = 1'b1;
  logic en_hi = 1'b1;
  logic en_lo = 1'b1;
  logic gate_hi;
  logic gate_lo;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int overlap_n = 0;
  int rise_hi = -1, fall_hi = -1, rise_lo = -1, fall_lo = -1;
  logic ph = 1'b0, pl = 1'b0;
  bit done = 1'b0;

  hb_deadtime_guard #(.DT_CYCLES(DT), .SYNC_STAGES(STG)) u0 (
    .clk(clk), .rst(rst), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
    .en_hi(en_hi), .en_lo(en_lo), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Edge recorder, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (gate_hi && !ph) rise_hi = cyc;
      if (!gate_hi && ph) fall_hi = cyc;
      if (gate_lo && !pl) rise_lo = cyc;
      if (!gate_lo && pl) fall_lo = cyc;
      if (gate_hi && gate_lo) overlap_n++;
    end
    ph = gate_hi;
    pl = gate_lo;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // Switch from one gate to the other with a commanded gap of g cycles
  task automatic gap_case(bit lo_to_hi, int g);
    int d, f, r, e;
    if (lo_to_hi) begin cmd_hi_n = 1'b1; cmd_lo_n = 1'b0; end
    else          begin cmd_lo_n = 1'b1; cmd_hi_n = 1'b0; end
    step(DT + LAT + 6);
    d = cyc;
    if (lo_to_hi) cmd_lo_n = 1'b1; else cmd_hi_n = 1'b1;
    step(g);
    if (lo_to_hi) cmd_hi_n = 1'b0; else cmd_lo_n = 1'b0;
    step(DT + LAT + 8);
    f = lo_to_hi ? fall_lo : fall_hi;
    r = lo_to_hi ? rise_hi : rise_lo;
    chk("R4 turn-off latency", f - d, LAT);
    e = (g > DT) ? g : DT;
    if (g < DT) chk("R5 gap stretched", r - f, e);
    else begin
      chk("R6 gap kept", r - f, e);
      chk("R4 turn-on latency", r - (d + g), LAT);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int d;
    logic [1:0] pa, pb;
    step(3);
    chk("R9 gate_hi in reset", int'(gate_hi), 0);
    chk("R9 gate_lo in reset", int'(gate_lo), 0);
    rst = 1'b0;
    step(10);

    // R1 / R3: all transitions between the four input pairs {hi_n, lo_n}
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        pa = 2'(a);
        pb = 2'(b);
        {cmd_hi_n, cmd_lo_n} = pa;
        step(12);
        {cmd_hi_n, cmd_lo_n} = pb;
        step(12);
        if (pb == 2'b00) begin
          chk("R3 both low gate_hi", int'(gate_hi), 0);
          chk("R3 both low gate_lo", int'(gate_lo), 0);
        end else begin
          chk("R1 gate_hi", int'(gate_hi), (pb == 2'b01) ? 1 : 0);
          chk("R1 gate_lo", int'(gate_lo), (pb == 2'b10) ? 1 : 0);
        end
      end
    end

    // R3 from an active gate: upper on, then lower also requested
    cmd_hi_n = 1'b0; cmd_lo_n = 1'b1;
    step(12);
    d = cyc;
    cmd_lo_n = 1'b0;
    step(10);
    chk("R3 upper drops on dual request", fall_hi - d, LAT);
    chk("R3 lower stays off", int'(gate_lo), 0);

    // R5 / R6 / R4: gap sweep in both directions
    for (int g = 0; g <= DT + 3; g++) begin
      gap_case(1'b1, g);
      gap_case(1'b0, g);
    end

    // R7: enables cut each gate at the next edge and restore it
    cmd_hi_n = 1'b0; cmd_lo_n = 1'b1;
    step(12);
    d = cyc; en_hi = 1'b0;
    step(5);
    chk("R7 en_hi cut", fall_hi - d, 1);
    chk("R7 gate_hi held off", int'(gate_hi), 0);
    d = cyc; en_hi = 1'b1;
    step(5);
    chk("R7 en_hi restore", rise_hi - d, 1);

    cmd_hi_n = 1'b1; cmd_lo_n = 1'b0;
    step(12);
    d = cyc; en_lo = 1'b0;
    step(5);
    chk("R7 en_lo cut", fall_lo - d, 1);
    d = cyc; en_lo = 1'b1;
    step(5);
    chk("R7 en_lo restore", rise_lo - d, 1);

    // R8: opposite enable low holds a fresh request and restarts the wait
    cmd_hi_n = 1'b1; cmd_lo_n = 1'b1;
    step(12);
    en_lo = 1'b0; cmd_hi_n = 1'b0;
    step(8);
    chk("R8 upper blocked while en_lo low", int'(gate_hi), 0);
    d = cyc; en_lo = 1'b1;
    step(10);
    chk("R8 upper waits after en_lo release", rise_hi - d, DT);

    cmd_hi_n = 1'b1; cmd_lo_n = 1'b1;
    step(12);
    en_hi = 1'b0; cmd_lo_n = 1'b0;
    step(8);
    chk("R8 lower blocked while en_hi low", int'(gate_lo), 0);
    d = cyc; en_hi = 1'b1;
    step(10);
    chk("R8 lower waits after en_hi release", rise_lo - d, DT);

    chk("R2 overlap cycles", overlap_n, 0);
    report();
    $finish;
  end
endmodule